// File: doc/BRIEF.md
# Product-Term Array with Steering Allocator

This block is the sum-of-products core of a programmable logic model. It receives a set of routed input signals and offers each of them to a programmable AND plane in true and in inverted form. Every product term in the plane is the AND of whichever of those literals its configuration selects. A steering allocator then builds each sum output as the OR of a configured subset of the product terms. All terms come from one shared pool, so a term that several outputs need is built once and fanned out to all of them. There is no fixed number of terms per output.

The configuration is a single serial chain. While `load_en` is high, one bit enters on `cfg_bit` at each clock edge. Once loading ends, the block evaluates combinationally from `in_sig` to `sum_o`. The configuration never changes outside a load. A rule check flags any output that is steered more terms than it may take. While the flag is set, every sum is held at zero. While a load is in progress, the outputs and the flag stay frozen at the values they had just before the load started.

Top module: `pterm_alloc_block`

## Requirements
- R1: Literal column 2*i carries input i in true form and column 2*i+1 carries its complement. An enabled product term is 1 exactly when every literal selected in its mask is 1.
- R2: A product term whose enable bit is 0 evaluates to 0, whatever its literal mask holds.
- R3: Each sum output is the OR of the product terms steered to it. An output with no steered terms is 0.
- R4: One product term may be steered to several outputs at the same time, and each of those outputs sees it.
- R5: An output steered exactly 16 terms is valid. It evaluates normally and does not raise the error flag.
- R6: If any output has more than 16 steering bits set, `cfg_err_o` is 1 and every bit of `sum_o` is 0.
- R7: While `load_en` is high, `sum_o` and `cfg_err_o` keep the values they had at the last clock edge before the load began, even if the inputs change.
- R8: The chain is shifted MSB first, with the new bit entering at bit 0. After a complete load, bit o*86+p is the steering of term p to output o, bit 1376+p is the enable of term p, and bit 1462+p*72+k is literal k of term p.
- R9: A synchronous active-low reset clears the whole configuration and the held outputs. After reset, `sum_o` is 0 and `cfg_err_o` is 0.
- R10: An enabled product term with an empty literal mask evaluates to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the hold registers |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | High while configuration bits are shifted in |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| in_sig | input | 36 | Routed input signals |
| sum_o | output | 16 | Sum-of-products outputs |
| cfg_err_o | output | 1 | Steering rule violation flag |

## Verification
When loading is idle, the sums and the error flag are combinational functions of `in_sig` and the stored configuration. They are due in the same cycle that an input changes. The bench therefore drives each vector on a falling edge and compares a couple of time units later, before the next rising edge. Each configuration bit is shifted in on the rising edge that follows its falling-edge drive, so a full load takes exactly one edge per chain bit. The new configuration is checked only after `load_en` has dropped. For the hold rule, the bench records the expected outputs before the load starts, with the inputs held steady across the last capturing edge. In the middle of the load it changes the inputs and compares the frozen outputs against that record.

// File: rtl/pta_pkg.sv
// Package: default sizes of the product-term block and the shared typedefs.
// Assumes: nothing; pure declarations.
package pta_pkg;
    localparam int DEF_N_IN      = 36;
    localparam int DEF_N_PT      = 86;
    localparam int DEF_N_OUT     = 16;
    localparam int DEF_MAX_TERMS = 16;

    // Captured outputs kept while a configuration load runs
    typedef struct packed {
        logic        err;
        logic [DEF_N_OUT-1:0] sums;
    } held_t;
endpackage

// File: rtl/pta_cfg_chain.sv
// Module: serial configuration store. One long shift register splits into
// the literal masks, the term enables and the steering bitmap.
// Assumes: load_en is high for exactly one edge per configuration bit.
module pta_cfg_chain #(
    parameter int N_LIT = 72,
    parameter int N_PT  = 86,
    parameter int N_OUT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic                         cfg_bit,
    output logic [N_PT-1:0][N_LIT-1:0]   lit_mask,
    output logic [N_PT-1:0]              term_en,
    output logic [N_OUT-1:0][N_PT-1:0]   steer
);
    localparam int STEER_BITS = N_OUT * N_PT;
    localparam int EN_BASE    = STEER_BITS;
    localparam int LIT_BASE   = EN_BASE + N_PT;
    localparam int TOTAL      = LIT_BASE + N_PT * N_LIT;

    logic [TOTAL-1:0] chain_q;

    // Shift register: clear on reset, shift one bit in at bit 0 while loading
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (load_en)
            chain_q <= {chain_q[TOTAL-2:0], cfg_bit};
    end

    // Field split: a fixed slice of the chain for each term and output
    for (genvar p = 0; p < N_PT; p++) begin : g_term_fields
        assign lit_mask[p] = chain_q[LIT_BASE + p*N_LIT +: N_LIT];
        assign term_en[p]  = chain_q[EN_BASE + p];
    end
    for (genvar o = 0; o < N_OUT; o++) begin : g_steer_fields
        assign steer[o] = chain_q[o*N_PT +: N_PT];
    end
endmodule

// File: rtl/pta_and_plane.sv
// Module: programmable AND plane. Forms both polarities of each input and
// ANDs the selected literals into each product term.
// Assumes: an empty mask with the enable set gives a constant 1.
module pta_and_plane #(
    parameter int N_IN = 36,
    parameter int N_PT = 86
) (
    input  logic [N_IN-1:0]               in_sig,
    input  logic [N_PT-1:0][2*N_IN-1:0]   lit_mask,
    input  logic [N_PT-1:0]               term_en,
    output logic [N_PT-1:0]               terms
);
    localparam int N_LIT = 2 * N_IN;

    logic [N_LIT-1:0] literals;

    // Literal columns: even column true, odd column inverted
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign literals[2*i]   = in_sig[i];
        assign literals[2*i+1] = ~in_sig[i];
    end

    // Product terms: unselected columns count as 1; the enable gates the result
    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        assign terms[p] = term_en[p] & (&(literals | ~lit_mask[p]));
    end
endmodule

// File: rtl/pta_allocator.sv
// Module: term steering allocator. ORs the steered terms into each sum and
// flags any output that is steered more than MAX_TERMS terms.
// Assumes: steering is static outside configuration loads.
module pta_allocator #(
    parameter int N_PT      = 86,
    parameter int N_OUT     = 16,
    parameter int MAX_TERMS = 16
) (
    input  logic [N_PT-1:0]              terms,
    input  logic [N_OUT-1:0][N_PT-1:0]   steer,
    output logic [N_OUT-1:0]             sums,
    output logic                         rule_err
);
    localparam int CNT_W = $clog2(N_PT + 1);

    logic [N_OUT-1:0] over_limit;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [CNT_W-1:0] n_set;

        // Sum: OR of every term this output is steered to
        assign sums[o] = |(steer[o] & terms);

        // Population count of this output's steering row
        always_comb begin
            n_set = '0;
            for (int p = 0; p < N_PT; p++)
                n_set = n_set + CNT_W'(steer[o][p]);
        end

        assign over_limit[o] = (n_set > CNT_W'(MAX_TERMS));
    end

    assign rule_err = |over_limit;
endmodule

// File: rtl/pterm_alloc_block.sv
// Module: top of the product-term array with steering allocator. Combines
// the configuration chain, the AND plane and the allocator, gates the sums
// on a rule error, and freezes the outputs while a load is in progress.
// Assumes: synchronous active-low reset; inputs stable around clock edges.
module pterm_alloc_block #(
    parameter int N_IN      = pta_pkg::DEF_N_IN,
    parameter int N_PT      = pta_pkg::DEF_N_PT,
    parameter int N_OUT     = pta_pkg::DEF_N_OUT,
    parameter int MAX_TERMS = pta_pkg::DEF_MAX_TERMS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_sig,
    output logic [N_OUT-1:0] sum_o,
    output logic             cfg_err_o
);
    localparam int N_LIT = 2 * N_IN;

    logic [N_PT-1:0][N_LIT-1:0] lit_mask;
    logic [N_PT-1:0]            term_en;
    logic [N_OUT-1:0][N_PT-1:0] steer;
    logic [N_PT-1:0]            terms;
    logic [N_OUT-1:0]           raw_sums;
    logic                       rule_err;
    logic [N_OUT-1:0]           live_sums;
    logic [N_OUT-1:0]           held_sums;
    logic                       held_err;

    pta_cfg_chain #(.N_LIT(N_LIT), .N_PT(N_PT), .N_OUT(N_OUT)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .cfg_bit  (cfg_bit),
        .lit_mask (lit_mask),
        .term_en  (term_en),
        .steer    (steer)
    );

    pta_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_plane (
        .in_sig   (in_sig),
        .lit_mask (lit_mask),
        .term_en  (term_en),
        .terms    (terms)
    );

    pta_allocator #(.N_PT(N_PT), .N_OUT(N_OUT), .MAX_TERMS(MAX_TERMS)) u_alloc (
        .terms    (terms),
        .steer    (steer),
        .sums     (raw_sums),
        .rule_err (rule_err)
    );

    // Error gating: a rule violation forces every sum low
    assign live_sums = rule_err ? '0 : raw_sums;

    // Hold registers: track the live result whenever no load is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_sums <= '0;
            held_err  <= 1'b0;
        end else if (!load_en) begin
            held_sums <= live_sums;
            held_err  <= rule_err;
        end
    end

    // Output select: frozen copy during a load, live logic otherwise
    assign sum_o     = load_en ? held_sums : live_sums;
    assign cfg_err_o = load_en ? held_err  : rule_err;
endmodule

// File: rtl/pterm_alloc_block_chk.sv
// Module: property checker for pterm_alloc_block, attached by bind.
// Assumes: it sees the top's ports plus the steering, enables and terms.
module pterm_alloc_block_chk #(
    parameter int N_PT  = 86,
    parameter int N_OUT = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_en,
    input logic [N_OUT-1:0]           sum_o,
    input logic                       cfg_err_o,
    input logic [N_OUT-1:0][N_PT-1:0] steer,
    input logic [N_PT-1:0]            term_en,
    input logic [N_PT-1:0]            terms
);
    // R7: outputs stay frozen across consecutive load cycles
    a_r7_hold_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && $past(load_en) && $past(rst_n)) |-> ($stable(sum_o) && $stable(cfg_err_o)));

    // R6: a raised error flag comes with all sums low
    a_r6_err_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (sum_o == '0));

    // R9: the first cycle after reset shows a cleared block
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((sum_o == '0) && !cfg_err_o));

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        // R3: an output with an empty steering row stays low
        a_r3_unsteered_low: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_en && (steer[o] == '0)) |-> !sum_o[o]);
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term_chk
        // R2: a disabled term never evaluates true
        a_r2_disabled_term: assert property (@(posedge clk) disable iff (!rst_n)
            !term_en[p] |-> !terms[p]);
    end
endmodule

bind pterm_alloc_block pterm_alloc_block_chk #(.N_PT(N_PT), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .sum_o     (sum_o),
    .cfg_err_o (cfg_err_o),
    .steer     (steer),
    .term_en   (term_en),
    .terms     (terms)
);

// File: tb/pterm_alloc_block_test.sv
// Bench: directed and seeded random configurations, checked against a
// model written from the requirements.
module pterm_alloc_block_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 36;
    localparam int N_LIT = 72;
    localparam int N_PT  = 86;
    localparam int N_OUT = 16;
    localparam int EN_BASE  = N_OUT * N_PT;
    localparam int LIT_BASE = EN_BASE + N_PT;
    localparam int TOTAL    = LIT_BASE + N_PT * N_LIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic cfg_bit = 1'b0;
    logic [N_IN-1:0] in_sig = '0;
    logic [N_OUT-1:0] sum_o;
    logic cfg_err_o;

    int n_checks = 0;
    int n_fails  = 0;

    bit lit_b [N_PT][N_LIT];
    bit en_b  [N_PT];
    bit st_b  [N_OUT][N_PT];

    pterm_alloc_block uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_bit(cfg_bit),
        .in_sig(in_sig), .sum_o(sum_o), .cfg_err_o(cfg_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference result {err, sums} for input vector x
    function automatic logic [N_OUT:0] model(logic [N_IN-1:0] x);
        bit t [N_PT];
        logic [N_OUT-1:0] s = '0;
        bit err = 0;
        for (int p = 0; p < N_PT; p++) begin
            t[p] = en_b[p];
            for (int k = 0; k < N_LIT; k++)
                if (lit_b[p][k] && (((k % 2) == 0) ? !x[k/2] : x[k/2])) t[p] = 0;
        end
        for (int o = 0; o < N_OUT; o++) begin
            int cnt = 0;
            for (int p = 0; p < N_PT; p++) begin
                if (st_b[o][p]) begin
                    cnt++;
                    if (t[p]) s[o] = 1'b1;
                end
            end
            if (cnt > 16) err = 1;
        end
        return err ? {1'b1, {N_OUT{1'b0}}} : {1'b0, s};
    endfunction

    function automatic bit chain_bit(int idx);
        if (idx < EN_BASE) return st_b[idx / N_PT][idx % N_PT];
        if (idx < LIT_BASE) return en_b[idx - EN_BASE];
        return lit_b[(idx - LIT_BASE) / N_LIT][(idx - LIT_BASE) % N_LIT];
    endfunction

    function automatic logic [N_IN-1:0] rnd_in();
        return {$urandom, $urandom};
    endfunction

    task automatic clear_cfg();
        for (int p = 0; p < N_PT; p++) begin
            en_b[p] = 0;
            for (int k = 0; k < N_LIT; k++) lit_b[p][k] = 0;
            for (int o = 0; o < N_OUT; o++) st_b[o][p] = 0;
        end
    endtask

    task automatic check(string req, logic [N_OUT:0] act, logic [N_OUT:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got err=%b sums=%h, expected err=%b sums=%h",
                     req, act[N_OUT], act[N_OUT-1:0], exp[N_OUT], exp[N_OUT-1:0]);
        end
    endtask

    // Drive a vector on a falling edge and compare before the next rising edge
    task automatic apply(string req, logic [N_IN-1:0] x);
        @(negedge clk);
        in_sig = x;
        #2;
        check(req, {cfg_err_o, sum_o}, model(x));
    endtask

    // R8 order: MSB of the chain first; R7 probe halfway through the load
    task automatic load_cfg(logic [N_OUT:0] held);
        @(negedge clk);
        load_en = 1'b1;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            cfg_bit = chain_bit(i);
            if (i == TOTAL / 2) begin
                in_sig = rnd_in();
                #2;
                check("R7", {cfg_err_o, sum_o}, held);
            end
            @(negedge clk);
        end
        load_en = 1'b0;
    endtask

    task automatic random_cfg();
        clear_cfg();
        for (int p = 0; p < N_PT; p++) begin
            int nl = 1 + ($urandom % 3);
            en_b[p] = ($urandom % 8) != 0;
            for (int j = 0; j < nl; j++) lit_b[p][$urandom % N_LIT] = 1;
        end
        for (int o = 0; o < N_OUT; o++) begin
            int nt = $urandom % 17;
            for (int j = 0; j < nt; j++) st_b[o][$urandom % N_PT] = 1;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [N_OUT:0] held;
        void'($urandom(32'h1d5e_a7c3));
        clear_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: cleared configuration drives everything low
        for (int v = 0; v < 3; v++) apply("R9", rnd_in());

        // R1 R2 R3 R4 R8 R10: directed polarity, enable, empty and sharing config
        held = model(in_sig);
        clear_cfg();
        en_b[0] = 1; lit_b[0][0] = 1; st_b[0][0] = 1;          // in0 true
        en_b[1] = 1; lit_b[1][1] = 1; st_b[1][1] = 1;          // in0 inverted
        en_b[2] = 1;                  st_b[2][2] = 1;          // empty mask
        en_b[3] = 0; lit_b[3][0] = 1; st_b[3][3] = 1;          // disabled
        en_b[4] = 1; lit_b[4][2] = 1; lit_b[4][4] = 1;         // in1 & in2
        for (int o = 4; o < N_OUT; o++) if (o != 5) st_b[o][4] = 1;
        load_cfg(held);
        for (int v = 0; v < 8; v++) begin
            logic [N_IN-1:0] x = rnd_in();
            x[2:0] = v[2:0];
            apply("R1 R2 R3 R4 R10", x);
        end

        // R5: one output with exactly sixteen single-literal terms
        held = model(in_sig);
        clear_cfg();
        for (int p = 10; p < 26; p++) begin
            en_b[p] = 1; lit_b[p][2*(p-10)] = 1; st_b[0][p] = 1;
        end
        load_cfg(held);
        apply("R5", '0);
        for (int j = 0; j < 16; j++) apply("R5", N_IN'(1) << j);
        apply("R5", {20'hfffff, 16'h0});

        // R6: a seventeenth steering bit on the same output
        held = model(in_sig);
        en_b[26] = 1; lit_b[26][40] = 1; st_b[0][26] = 1;
        st_b[7][26] = 1;
        load_cfg(held);
        for (int v = 0; v < 4; v++) apply("R6", rnd_in());
        apply("R6", '1);

        // R3: random shared-pool configurations
        for (int c = 0; c < 6; c++) begin
            held = model(in_sig);
            random_cfg();
            load_cfg(held);
            for (int v = 0; v < 20; v++) apply("R3", rnd_in());
        end

        summary();
        $finish;
    end
endmodule